// File: doc/BRIEF.md
# Redundant Module Failover Arbiter

This block decides whether a chassis management module is the active controller or the standby controller when a second module sits beside it as a redundant peer. The two modules are wired to each other through three cross-connected lines: a presence line, a healthy line and a negotiate line. The arbiter resamples the peer's three lines, watches its own local health and a software request to hand over, and drives its own healthy and negotiate lines plus an active flag and two status LED drives.

After reset the arbiter waits through a settle window. A module without a peer then takes control. When both modules are present, a fixed strap input breaks the tie. Later handovers go in one of two directions. The active side gives up control by raising its healthy line, which is active low. The standby side asks for control by pulling its negotiate line low, and the active side answers by releasing. Between one owner letting go and the other taking over there is always a guard window in which neither is active. The presence output is tied low, so the peer always sees this module as fitted.

Top module: `failover_arbiter`

## Requirements
- R1: During reset `is_active`=0, `own_hlth_n`=1, `own_neg`=1 and `led_green`=0. `own_pres_n` is 0 at all times.
- R2: With the peer absent (`peer_pres_n`=1), `is_active` stays 0 for the first SETTLE_CYC-1 clock edges after reset is released and becomes 1 on edge SETTLE_CYC.
- R3: With the peer present at the end of the settle window, the module becomes active on edge SETTLE_CYC when `prefer_active`=1. When `prefer_active`=0 it stays standby, provided the peer is healthy.
- R4: `own_hlth_n` equals the inverse of `local_ok` one edge after `local_ok` changes, except during a release.
- R5: When a request arrives while the module is active and the peer is present and healthy (`peer_pres_n`=0, `peer_hlth_n`=0), `is_active` drops on the next edge. `own_hlth_n` then stays 1 for exactly GUARD_CYC samples, and the module settles in standby.
- R6: When a request arrives while the module is active and the peer is absent or unhealthy, the request is refused and the module stays active with `own_hlth_n`=0.
- R7: A request made while the module is in standby with `local_ok`=1 drives `own_neg` to 0 on the next edge. The module stays inactive while the peer's healthy line is low. Once `peer_hlth_n` goes to 1, it becomes active exactly 2*SYNC_STAGES+GUARD_CYC+3 edges later, and `own_neg` returns to 1.
- R8: While the module is active, a present peer that drives `peer_neg`=0 makes `is_active` drop exactly SYNC_STAGES+1 edges later.
- R9: In standby with `local_ok`=1, the module stays standby while the peer is present and healthy. If the peer disappears (`peer_pres_n`=1), it becomes active exactly 2*SYNC_STAGES+GUARD_CYC+3 edges later.
- R10: With two arbiters cross-wired, they are never active at the same time. Every change of owner leaves at least GUARD_CYC samples in which neither is active.
- R11: When `local_ok`=0, `led_red` is 1 and `led_green` is 0. When `local_ok`=1, `led_green` is steadily 1 while active. In standby it toggles every 2^BLINK_LOG2 cycles.
- R12: An active module that loses `local_ok` releases on the next edge if the peer is present and healthy. Otherwise it stays active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| peer_pres_n | input | 1 | Peer presence line, 0 = peer fitted |
| peer_hlth_n | input | 1 | Peer healthy line, 0 = healthy |
| peer_neg | input | 1 | Peer negotiate line, 0 = peer claims control |
| local_ok | input | 1 | Local health status, 1 = healthy |
| sw_fail_req | input | 1 | Software handover request, one-cycle pulse |
| prefer_active | input | 1 | Tie-break strap, 1 = win when both are present at start |
| own_pres_n | output | 1 | Own presence line, tied to 0 |
| own_hlth_n | output | 1 | Own healthy line, 0 = healthy |
| own_neg | output | 1 | Own negotiate line, 0 = claiming control |
| is_active | output | 1 | 1 = this module is the active one |
| led_green | output | 1 | Green status LED drive |
| led_red | output | 1 | Red status LED drive |

## Verification
The dangerous coincidence comes in two forms. The first is a standby claim on the negotiate line that arrives while the active side is already releasing for its own software request. The second is both sides leaving standby in the same cycle after a health fault clears on each. A cross-wired pair is run with sparse random handover requests from both sides and random flips of each side's local health, so requests and health changes pile onto each other within the synchroniser latency. Each cycle the bench flags any sample in which both are active, and it measures the idle samples at every change of owner against the guard window.

// File: rtl/failover_pkg.sv
package failover_pkg;

  typedef enum logic [2:0] {
    ST_SETTLE,
    ST_STANDBY,
    ST_CLAIM,
    ST_GAP,
    ST_ACTIVE,
    ST_RELEASE
  } fo_state_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/failover_sync.sv
module failover_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] INIT  = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/failover_blink.sv
module failover_blink #(
  parameter int unsigned BLINK_LOG2 = 4
) (
  input  logic clk,
  input  logic rst,
  output logic phase
);

  localparam int unsigned CW = BLINK_LOG2 + 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign phase = cnt[CW-1];

endmodule

// File: rtl/failover_fsm.sv
module failover_fsm
  import failover_pkg::*;
#(
  parameter int unsigned SETTLE_CYC  = 256,
  parameter int unsigned GUARD_CYC   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic peer_pres_n_s,
  input  logic peer_hlth_n_s,
  input  logic peer_neg_s,
  input  logic local_ok,
  input  logic sw_req,
  input  logic prefer,
  input  logic blink,
  output logic own_hlth_n_q,
  output logic own_neg_q,
  output logic is_active_q,
  output logic led_grn_q,
  output logic led_red_q
);

  // takeover wait covers the guard window plus the peer's resample and react time
  localparam int unsigned GAP_CYC = GUARD_CYC + SYNC_STAGES + 2;
  localparam int unsigned CNT_MAX = max2(max2(SETTLE_CYC, GAP_CYC), GUARD_CYC);
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  fo_state_t        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  logic peer_ok, peer_claim, peer_gone;

  assign peer_ok    = !peer_pres_n_s && !peer_hlth_n_s;
  assign peer_claim = !peer_pres_n_s && !peer_neg_s;
  assign peer_gone  = peer_pres_n_s || peer_hlth_n_s;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    case (state_q)
      ST_SETTLE: begin
        if (cnt_q == CNT_W'(SETTLE_CYC - 1)) begin
          cnt_d   = '0;
          state_d = (peer_pres_n_s || prefer) ? ST_ACTIVE : ST_STANDBY;
        end
      end
      ST_STANDBY: begin
        cnt_d = '0;
        if (local_ok) begin
          if (peer_gone)   state_d = ST_GAP;
          else if (sw_req) state_d = ST_CLAIM;
        end
      end
      ST_CLAIM: begin
        cnt_d = '0;
        if (!local_ok)       state_d = ST_STANDBY;
        else if (peer_gone)  state_d = ST_GAP;
        else if (peer_claim) state_d = prefer ? ST_GAP : ST_STANDBY;
      end
      ST_GAP: begin
        if (!local_ok || (peer_claim && !prefer)) begin
          state_d = ST_STANDBY;
          cnt_d   = '0;
        end else if (cnt_q == CNT_W'(GAP_CYC - 1)) begin
          state_d = ST_ACTIVE;
          cnt_d   = '0;
        end
      end
      ST_ACTIVE: begin
        cnt_d = '0;
        if (peer_claim || (peer_ok && (sw_req || !local_ok))) state_d = ST_RELEASE;
      end
      ST_RELEASE: begin
        if (cnt_q == CNT_W'(GUARD_CYC - 1)) begin
          state_d = ST_STANDBY;
          cnt_d   = '0;
        end
      end
      default: begin
        state_d = ST_SETTLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_SETTLE;
      cnt_q        <= '0;
      is_active_q  <= 1'b0;
      own_neg_q    <= 1'b1;
      own_hlth_n_q <= 1'b1;
      led_red_q    <= 1'b0;
      led_grn_q    <= 1'b0;
    end else begin
      state_q      <= state_d;
      cnt_q        <= cnt_d;
      is_active_q  <= (state_d == ST_ACTIVE);
      own_neg_q    <= !((state_d == ST_CLAIM) || (state_d == ST_GAP));
      own_hlth_n_q <= (state_d == ST_RELEASE) || !local_ok;
      led_red_q    <= !local_ok;
      led_grn_q    <= local_ok && ((state_d == ST_ACTIVE) || blink);
    end
  end

  AST_SETTLE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SETTLE) |-> !is_active_q); // R2

  AST_REFUSE_REQ: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACTIVE && sw_req && !peer_ok && !peer_claim) |=> is_active_q); // R6

  AST_RELEASE_RAISES_HLTH: assert property (@(posedge clk) disable iff (rst)
    $fell(is_active_q) |-> own_hlth_n_q); // R5

  AST_RELEASE_TO_STANDBY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RELEASE) |=> (state_q == ST_RELEASE || state_q == ST_STANDBY)); // R5

  AST_TAKE_AFTER_CLAIM: assert property (@(posedge clk) disable iff (rst)
    $rose(is_active_q) |-> ($past(state_q) == ST_SETTLE || !$past(own_neg_q))); // R7

endmodule

// File: rtl/failover_arbiter.sv
module failover_arbiter #(
  parameter int unsigned SETTLE_CYC  = 256,
  parameter int unsigned GUARD_CYC   = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BLINK_LOG2  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic peer_pres_n,
  input  logic peer_hlth_n,
  input  logic peer_neg,
  input  logic local_ok,
  input  logic sw_fail_req,
  input  logic prefer_active,
  output logic own_pres_n,
  output logic own_hlth_n,
  output logic own_neg,
  output logic is_active,
  output logic led_green,
  output logic led_red
);

  localparam int unsigned NPEER = 3;

  logic [NPEER-1:0] peer_s;
  logic             blink;

  failover_sync #(
    .W      (NPEER),
    .STAGES (SYNC_STAGES),
    .INIT   ({NPEER{1'b1}})
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({peer_neg, peer_hlth_n, peer_pres_n}),
    .q   (peer_s)
  );

  failover_blink #(
    .BLINK_LOG2 (BLINK_LOG2)
  ) u_blink (
    .clk   (clk),
    .rst   (rst),
    .phase (blink)
  );

  failover_fsm #(
    .SETTLE_CYC  (SETTLE_CYC),
    .GUARD_CYC   (GUARD_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .peer_pres_n_s (peer_s[0]),
    .peer_hlth_n_s (peer_s[1]),
    .peer_neg_s    (peer_s[2]),
    .local_ok      (local_ok),
    .sw_req        (sw_fail_req),
    .prefer        (prefer_active),
    .blink         (blink),
    .own_hlth_n_q  (own_hlth_n),
    .own_neg_q     (own_neg),
    .is_active_q   (is_active),
    .led_grn_q     (led_green),
    .led_red_q     (led_red)
  );

  assign own_pres_n = 1'b0;

endmodule

// File: tb/failover_arbiter_test.sv
module failover_arbiter_test;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 256;
  localparam int GUARD      = 4;
  localparam int SYNC       = 2;
  localparam int BLINK      = 4;
  localparam int TAKE_LAT   = 2*SYNC + GUARD + 3;
  localparam int REL_LAT    = SYNC + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pair_mode = 1'b0;
  logic tb_pres_n = 1'b1, tb_hlth_n = 1'b1, tb_neg = 1'b1;
  logic ok_a = 1'b1, sw_a = 1'b0, pref_a = 1'b0;
  logic ok_b = 1'b1, sw_b = 1'b0, pref_b = 1'b0;

  logic a_pres_n, a_hlth_n, a_neg, a_act, a_grn, a_red;
  logic b_pres_n, b_hlth_n, b_neg, b_act, b_grn, b_red;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;
  int viol_both = 0, viol_gap = 0, handovers = 0, idle = 0, owner = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  failover_arbiter #(.SETTLE_CYC(SETTLE), .GUARD_CYC(GUARD), .SYNC_STAGES(SYNC), .BLINK_LOG2(BLINK)) uut (
    .clk(clk), .rst(rst),
    .peer_pres_n(pair_mode ? b_pres_n : tb_pres_n),
    .peer_hlth_n(pair_mode ? b_hlth_n : tb_hlth_n),
    .peer_neg(pair_mode ? b_neg : tb_neg),
    .local_ok(ok_a), .sw_fail_req(sw_a), .prefer_active(pref_a),
    .own_pres_n(a_pres_n), .own_hlth_n(a_hlth_n), .own_neg(a_neg),
    .is_active(a_act), .led_green(a_grn), .led_red(a_red));

  failover_arbiter #(.SETTLE_CYC(SETTLE), .GUARD_CYC(GUARD), .SYNC_STAGES(SYNC), .BLINK_LOG2(BLINK)) mate (
    .clk(clk), .rst(rst),
    .peer_pres_n(a_pres_n), .peer_hlth_n(a_hlth_n), .peer_neg(a_neg),
    .local_ok(ok_b), .sw_fail_req(sw_b), .prefer_active(pref_b),
    .own_pres_n(b_pres_n), .own_hlth_n(b_hlth_n), .own_neg(b_neg),
    .is_active(b_act), .led_green(b_grn), .led_red(b_red));

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_act(input logic want, output int k);
    k = 0;
    while (a_act !== want && k < 60) begin
      cyc(1);
      k++;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(3);
    rst = 1'b0;
  endtask

  function automatic bit pulse(input int unsigned odds);
    return ($urandom_range(odds - 1) == 0);
  endfunction

  // pair monitor: exclusivity and idle gap at each change of owner (R10)
  always @(negedge clk) begin
    if (mon_en) begin
      if (a_act && b_act) viol_both++;
      if (!a_act && !b_act) idle++;
      else begin
        if ((a_act && owner == 2) || (b_act && owner == 1)) begin
          handovers++;
          if (idle < GUARD) viol_gap++;
        end
        owner = a_act ? 1 : 2;
        idle = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int k;
    int t;
    logic prev;
    void'($urandom(32'd7321));
    @(negedge clk);
    cyc(2);
    chk("R1 active in reset", int'(a_act), 0);
    chk("R1 hlth_n in reset", int'(a_hlth_n), 1);
    chk("R1 neg in reset", int'(a_neg), 1);
    chk("R1 pres_n", int'(a_pres_n), 0);
    chk("R1 green in reset", int'(a_grn), 0);

    // R2: lone module takes control at the end of the settle window
    rst = 1'b0;
    cyc(SETTLE - 1);
    chk("R2 not yet active", int'(a_act), 0);
    cyc(1);
    chk("R2 active at settle end", int'(a_act), 1);
    chk("R11 steady green active", int'(a_grn), 1);

    // R6: request with no peer refused
    sw_a = 1'b1; cyc(1); sw_a = 1'b0;
    cyc(4);
    chk("R6 request refused", int'(a_act), 1);
    chk("R6 hlth kept", int'(a_hlth_n), 0);

    // R12 / R4 / R11: local fault without peer
    ok_a = 1'b0; cyc(2);
    chk("R12 stays active without peer", int'(a_act), 1);
    chk("R4 hlth_n follows fault", int'(a_hlth_n), 1);
    chk("R11 red on fault", int'(a_red), 1);
    chk("R11 green off on fault", int'(a_grn), 0);
    ok_a = 1'b1; cyc(2);
    chk("R4 hlth_n restored", int'(a_hlth_n), 0);
    chk("R11 red off", int'(a_red), 0);

    // R5: handover to a healthy peer
    tb_pres_n = 1'b0; tb_hlth_n = 1'b0; cyc(5);
    sw_a = 1'b1; cyc(1); sw_a = 1'b0;
    chk("R5 dropped active", int'(a_act), 0);
    k = 0;
    while (a_hlth_n === 1'b1 && k < 50) begin
      k++;
      cyc(1);
    end
    chk("R5 release window", k, GUARD);
    cyc(10);
    chk("R9 stays standby with healthy peer", int'(a_act), 0);

    // R11: blink in standby
    t = 0; prev = a_grn;
    repeat (64) begin
      cyc(1);
      if (a_grn != prev) t++;
      prev = a_grn;
    end
    chk("R11 standby blink toggles", t, 64 / (1 << BLINK));

    // R7: standby claim
    sw_a = 1'b1; cyc(1); sw_a = 1'b0;
    chk("R7 neg driven low", int'(a_neg), 0);
    cyc(15);
    chk("R7 waits while peer healthy", int'(a_act), 0);
    chk("R7 neg held low", int'(a_neg), 0);
    tb_hlth_n = 1'b1;
    wait_act(1'b1, k);
    chk("R7 takeover latency", k, TAKE_LAT);
    chk("R7 neg released when active", int'(a_neg), 1);

    // R8: peer claims while active
    tb_hlth_n = 1'b0; cyc(5);
    tb_neg = 1'b0;
    wait_act(1'b0, k);
    chk("R8 release latency", k, REL_LAT);
    tb_neg = 1'b1;
    cyc(10);
    chk("R8 standby after release", int'(a_act), 0);

    // R9: peer disappears
    tb_pres_n = 1'b1;
    wait_act(1'b1, k);
    chk("R9 takeover on peer loss", k, TAKE_LAT);

    // R12: local fault with healthy peer
    tb_pres_n = 1'b0; tb_hlth_n = 1'b0; cyc(5);
    ok_a = 1'b0; cyc(1);
    chk("R12 releases to healthy peer", int'(a_act), 0);
    cyc(10);
    chk("R4 hlth_n high while faulty standby", int'(a_hlth_n), 1);
    ok_a = 1'b1; cyc(1);
    chk("R4 hlth_n low after recovery", int'(a_hlth_n), 0);

    // R3: tie-break with peer present
    pref_a = 1'b1; do_reset(); cyc(SETTLE);
    chk("R3 preferred takes control", int'(a_act), 1);
    pref_a = 1'b0; do_reset(); cyc(SETTLE);
    chk("R3 non-preferred standby", int'(a_act), 0);
    cyc(20);
    chk("R3 non-preferred stays standby", int'(a_act), 0);

    // R10: cross-wired pair under random stimulus
    pair_mode = 1'b1; pref_a = 1'b1; pref_b = 1'b0; ok_a = 1'b1; ok_b = 1'b1;
    do_reset(); cyc(SETTLE + 4);
    chk("R3 pair preferred active", int'(a_act), 1);
    chk("R3 pair other standby", int'(b_act), 0);
    mon_en = 1'b1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      sw_a = pulse(97);
      sw_b = pulse(89);
      if (pulse(300)) ok_a = ~ok_a;
      if (pulse(300)) ok_b = ~ok_b;
    end
    sw_a = 1'b0; sw_b = 1'b0;
    cyc(2);
    mon_en = 1'b0;
    chk("R10 both active samples", viol_both, 0);
    chk("R10 short guard gaps", viol_gap, 0);
    chk("R10 handovers seen", int'(handovers > 0), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule